// File: doc/BRIEF.md
# Software-Paced I2C Bus Master

This block is an I2C bus master run step by step by software through five byte-wide registers on a simple read/write port. A single write to the status register names the bus direction (master transmit or master receive) and asks for a START or a STOP. The controller sends the contents of the data register as the address byte after a START. After each byte and its acknowledge slot, it parks the bus with SCL held low and raises a pending flag. Nothing more happens on the bus until software writes 0 to that flag. Software uses each pause to load the next byte to send, to read the byte just received, to change the acknowledge policy, or to queue a repeated START or a STOP.

SCL and SDA leave the block as open-drain pull-down enables. A 1 on `scl_oe` or `sda_oe` pulls the line low, and a 0 releases it to the pull-up. The returning SDA level is sampled in the middle of each SCL high phase. Each SCL period is split into four equal quarters, and SDA only moves on the boundary between the two low quarters.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, every register reads 0, the bus is idle with both lines released (`scl_oe` = 0, `sda_oe` = 0), and `irq` is 0.
- R2: Byte offsets are control 0x00, status 0x04, own address 0x08, data 0x0C and line control 0x10. Control, own address and line control read back what was written, except for control bit 4. Any other offset reads 0.
- R3: Control bits 3:0 hold the divisor N and bit 6 the prescaler P (0 means 16, 1 means 512). One SCL period lasts P·(N+1) clock cycles.
- R4: A status write with bit 7 = 1, bit 5 = 1 and bit 4 = 1 produces a START (SDA falls while SCL is high) and then shifts out the data register, MSB first, as the address byte. Status bits 7:6 select the mode: 11 is master transmit and 10 is master receive. On a status read, bit 5 is 1 while the bus is busy.
- R5: A START request whose status bit 4 (enable) is 0, or whose bit 7 is 0 (a slave mode), has no effect on the bus, and busy stays 0.
- R6: After every byte and its acknowledge slot, control bit 4 (pending) becomes 1 and SCL stays low. No further bus activity takes place until software writes that bit to 0. Writing 1 to it never sets it.
- R7: In master transmit, a data byte goes out MSB first, and the SDA level sampled in the ninth clock is stored in status bit 0 (1 means not acknowledged).
- R8: In master receive, the eight sampled bits land MSB first in the data register. In the ninth clock the master pulls SDA low if control bit 7 is 1 and releases it if control bit 7 is 0.
- R9: A status write with bit 5 = 0 while busy in a master mode, followed by clearing pending, produces a STOP (SDA rises while SCL is high). Busy then reads 0 and both lines are released.
- R10: A START request while the bus is still held (busy, paused) produces a new START once pending is cleared, with no STOP in between.
- R11: `irq` is 1 exactly when pending is 1 and control bit 5 (interrupt enable) is 1. Pending can be read whatever the enable is.
- R12: Except for the START and STOP edges themselves, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SCL is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt: pending and enabled |
| sda_in | input | 1 | Level observed on the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The properties assume that software changes the control, status and data registers only while the controller is paused or idle, and never changes the acknowledge enable in the middle of a byte. They also assume that the far end moves SDA only while SCL is low and never stretches SCL, because the block does not watch the SCL wire. The bench keeps to these assumptions in two ways. Every register write waits for pending to read back as 1, or for busy to read back as 0. The modelled slave updates its SDA pull-down only on a falling SCL edge, releases the line after a NACK from the master, and acknowledges address bytes and written bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_START,
        ENG_BIT,
        ENG_HOLD,
        ENG_STOP
    } eng_st_e;

    // Control register, MSB first as seen by software.
    typedef struct packed {
        logic       ackgen;
        logic       pres_slow;
        logic       ie;
        logic       pend;
        logic [3:0] div;
    } ctl_t;

    typedef struct packed {
        ctl_t       ctl;
        logic [1:0] mode;
        logic       en;
        logic [7:0] own;
        logic [7:0] data;
        logic [7:0] line;
        logic       req_start;
        logic       req_stop;
    } ctrl_t;

    localparam logic [1:0] MODE_MRX = 2'b10;
    localparam logic [1:0] MODE_MTX = 2'b11;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int Q_FAST = PRE_FAST / 4;
    localparam int Q_SLOW = PRE_SLOW / 4;
    localparam int MAXC   = Q_SLOW * (1 << DIV_W);
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_t;

    tick_t       st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = CW'((slow ? Q_SLOW : Q_FAST) * (int'(div) + 1));
        tick = run && (st_q.cnt == lim - CW'(1));
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2cm_byte_eng.sv
module i2cm_byte_eng
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_start,
    input  logic              go_byte,
    input  logic              go_stop,
    input  logic              tx_mode,
    input  logic              ack_gen,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              scl_low,
    output logic              sda_low,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_bit,
    output logic              cur_tx,
    output logic              idle,
    output logic              hold,
    output logic              active,
    output logic              in_bit
);
    localparam int BN_W = $clog2(BYTE_W + 1);
    localparam logic [BN_W-1:0] ACK_SLOT = BN_W'(BYTE_W);

    typedef struct packed {
        eng_st_e           st;
        logic [1:0]        q;
        logic [BN_W-1:0]   bn;
        logic [BYTE_W-1:0] sh;
        logic              tx;
        logic              ack;
        logic              scl_low;
        logic              sda_low;
    } eng_t;

    eng_t st_d, st_q;
    logic done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q.st)
            ENG_IDLE: begin
                if (go_start) begin
                    st_d.st = ENG_START;
                    st_d.q  = 2'd2;
                    st_d.sh = tx_data;
                    st_d.tx = 1'b1;
                end
            end
            ENG_HOLD: begin
                if (go_start) begin
                    st_d.st = ENG_START;
                    st_d.q  = 2'd0;
                    st_d.sh = tx_data;
                    st_d.tx = 1'b1;
                end else if (go_stop) begin
                    st_d.st = ENG_STOP;
                    st_d.q  = 2'd0;
                end else if (go_byte) begin
                    st_d.st = ENG_BIT;
                    st_d.q  = 2'd0;
                    st_d.bn = '0;
                    st_d.sh = tx_data;
                    st_d.tx = tx_mode;
                end
            end
            ENG_START: begin
                if (tick) begin
                    if (st_q.q == 2'd3) begin
                        st_d.st = ENG_BIT;
                        st_d.q  = 2'd0;
                        st_d.bn = '0;
                    end else begin
                        st_d.q = st_q.q + 2'd1;
                    end
                end
            end
            ENG_BIT: begin
                if (tick) begin
                    st_d.q = st_q.q + 2'd1;
                    if (st_q.q == 2'd1) begin
                        if (st_q.bn == ACK_SLOT) begin
                            if (st_q.tx) st_d.ack = sda_in;
                        end else if (!st_q.tx) begin
                            st_d.sh = {st_q.sh[BYTE_W-2:0], sda_in};
                        end
                    end
                    if (st_q.q == 2'd3) begin
                        if (st_q.bn == ACK_SLOT) begin
                            st_d.st = ENG_HOLD;
                            done    = 1'b1;
                        end else begin
                            st_d.bn = st_q.bn + BN_W'(1);
                            if (st_q.tx) st_d.sh = {st_q.sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ENG_STOP: begin
                if (tick) begin
                    if (st_q.q == 2'd2) begin
                        st_d.st = ENG_IDLE;
                        st_d.q  = 2'd0;
                    end else begin
                        st_d.q = st_q.q + 2'd1;
                    end
                end
            end
            default: st_d.st = ENG_IDLE;
        endcase

        // Line levels follow the next state so they leave a flop directly.
        unique case (st_d.st)
            ENG_IDLE: begin
                st_d.scl_low = 1'b0;
                st_d.sda_low = 1'b0;
            end
            ENG_HOLD: begin
                st_d.scl_low = 1'b1;
                st_d.sda_low = 1'b0;
            end
            ENG_START: begin
                st_d.scl_low = (st_d.q == 2'd0) || (st_d.q == 2'd3);
                st_d.sda_low = st_d.q[1];
            end
            ENG_BIT: begin
                st_d.scl_low = (st_d.q == 2'd0) || (st_d.q == 2'd3);
                if (st_d.bn == ACK_SLOT) begin
                    st_d.sda_low = st_d.tx ? 1'b0 : ack_gen;
                end else begin
                    st_d.sda_low = st_d.tx ? ~st_d.sh[BYTE_W-1] : 1'b0;
                end
            end
            ENG_STOP: begin
                st_d.scl_low = (st_d.q == 2'd0);
                st_d.sda_low = !st_d.q[1];
            end
            default: begin
                st_d.scl_low = 1'b0;
                st_d.sda_low = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ENG_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_low   = st_q.scl_low;
    assign sda_low   = st_q.sda_low;
    assign byte_done = done;
    assign rx_byte   = st_q.sh;
    assign ack_bit   = st_q.ack;
    assign cur_tx    = st_q.tx;
    assign idle      = (st_q.st == ENG_IDLE);
    assign hold      = (st_q.st == ENG_HOLD);
    assign active    = !idle && !hold;
    assign in_bit    = (st_q.st == ENG_BIT);

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_OWN  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] OFF_LINE = ADDR_W'(16);

    ctrl_t st_d, st_q;

    logic       tick;
    logic       go_start, go_byte, go_stop, can_go;
    logic       eng_done, eng_ack, eng_tx;
    logic       eng_idle, eng_hold, eng_active, eng_in_bit;
    logic [7:0] eng_rx;
    logic       busy;
    logic       pend_flag;

    i2cm_tick #(
        .PRE_FAST (PRE_FAST),
        .PRE_SLOW (PRE_SLOW),
        .DIV_W    (4)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_active),
        .slow  (st_q.ctl.pres_slow),
        .div   (st_q.ctl.div),
        .tick  (tick)
    );

    i2cm_byte_eng #(
        .BYTE_W (8)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go_start  (go_start),
        .go_byte   (go_byte),
        .go_stop   (go_stop),
        .tx_mode   (st_q.mode == MODE_MTX),
        .ack_gen   (st_q.ctl.ackgen),
        .sda_in    (sda_in),
        .tx_data   (st_q.data),
        .scl_low   (scl_oe),
        .sda_low   (sda_oe),
        .byte_done (eng_done),
        .rx_byte   (eng_rx),
        .ack_bit   (eng_ack),
        .cur_tx    (eng_tx),
        .idle      (eng_idle),
        .hold      (eng_hold),
        .active    (eng_active),
        .in_bit    (eng_in_bit)
    );

    always_comb begin
        st_d = st_q;
        busy = !eng_idle || st_q.req_start;

        // Bus steps are released only while not paused.
        can_go   = !st_q.ctl.pend && (eng_idle || eng_hold);
        go_start = can_go && st_q.req_start;
        go_stop  = can_go && eng_hold && !st_q.req_start && st_q.req_stop;
        go_byte  = can_go && eng_hold && !st_q.req_start && !st_q.req_stop;
        if (go_start) st_d.req_start = 1'b0;
        if (go_stop || (can_go && eng_idle && !st_q.req_start)) st_d.req_stop = 1'b0;

        if (reg_wr) begin
            if (reg_addr == OFF_CTL) begin
                st_d.ctl      = ctl_t'(reg_wdata);
                st_d.ctl.pend = st_q.ctl.pend & reg_wdata[4];
            end
            if (reg_addr == OFF_STAT) begin
                st_d.mode = reg_wdata[7:6];
                st_d.en   = reg_wdata[4];
                if (reg_wdata[5] && reg_wdata[4] && reg_wdata[7]) begin
                    st_d.req_start = 1'b1;
                    st_d.req_stop  = 1'b0;
                end else if (!reg_wdata[5] && st_q.mode[1] && busy) begin
                    st_d.req_stop = 1'b1;
                end
            end
            if (reg_addr == OFF_OWN)  st_d.own  = reg_wdata;
            if (reg_addr == OFF_DATA) st_d.data = reg_wdata;
            if (reg_addr == OFF_LINE) st_d.line = reg_wdata;
        end

        if (eng_done) begin
            st_d.ctl.pend = 1'b1;
            if (!eng_tx) st_d.data = eng_rx;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == OFF_CTL)  reg_rdata = st_q.ctl;
        if (reg_addr == OFF_STAT) reg_rdata = {st_q.mode, busy, st_q.en, 3'b000, eng_ack};
        if (reg_addr == OFF_OWN)  reg_rdata = st_q.own;
        if (reg_addr == OFF_DATA) reg_rdata = st_q.data;
        if (reg_addr == OFF_LINE) reg_rdata = st_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_flag = st_q.ctl.pend;
    assign irq       = st_q.ctl.pend & st_q.ctl.ie;

endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic pend,
    input logic eng_done,
    input logic eng_idle,
    input logic eng_in_bit
);

    // R12: during a bit, SDA holds still across a high SCL phase
    assert_sda_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_in_bit && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    // R6: while paused, SCL is held low
    assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> scl_oe);

    // R6: pending only rises after a completed byte
    assert_pend_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(eng_done));

    // R9: an idle engine leaves both lines released
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |-> (!scl_oe && !sda_oe));

endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .pend       (pend_flag),
    .eng_done   (eng_done),
    .eng_idle   (eng_idle),
    .eng_in_bit (eng_in_bit)
);

// File: tb/i2cm_ctrl_bench.sv
module i2cm_ctrl_bench;

    localparam logic [4:0] A_CTL  = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_OWN  = 5'h08;
    localparam logic [4:0] A_DATA = 5'h0C;
    localparam logic [4:0] A_LINE = 5'h10;
    localparam logic [4:0] A_NONE = 5'h14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe, sda_in;

    int n_chk = 0;
    int n_fail = 0;

    // Bus and slave model state
    logic       slv_pull = 1'b0;
    logic       slv_ack_en = 1'b1;
    logic [7:0] rd_q [0:3];
    int         rd_ptr = 0;
    int         cyc = 0;
    int         start_cnt = 0, stop_cnt = 0, viol_cnt = 0, byte_cnt = 0;
    int         rise_t [0:8];
    int         bitidx = 0;
    logic       armed = 1'b0, first = 1'b0, rd_dir = 1'b0;
    logic [7:0] cap = '0, last_byte = '0;
    logic       ack_line = 1'b0, last_mack = 1'b0;
    logic       scl_p = 1'b1, sda_p = 1'b1;
    logic       scl_w, sda_w;

    always #5 clk = ~clk;

    assign scl_w  = ~scl_oe;
    assign sda_w  = ~(sda_oe | slv_pull);
    assign sda_in = sda_w;

    i2cm_ctrl u_i2cm_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    // Slave model and line monitor, evaluated away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (scl_w && scl_p && sda_p && !sda_w) begin
            start_cnt = start_cnt + 1;
            bitidx = 0; armed = 1'b0; first = 1'b1; rd_dir = 1'b0;
            cap = '0; slv_pull = 1'b0;
        end else if (scl_w && scl_p && !sda_p && sda_w) begin
            stop_cnt = stop_cnt + 1;
            armed = 1'b0;
        end else if (scl_w && scl_p && (sda_w != sda_p)) begin
            viol_cnt = viol_cnt + 1;
        end
        if (scl_w && !scl_p) begin
            if (bitidx <= 8) rise_t[bitidx] = cyc;
            if (bitidx < 8) cap = {cap[6:0], sda_w};
            else ack_line = sda_w;
        end
        if (!scl_w && scl_p) begin
            if (!armed) begin
                armed = 1'b1;
            end else if (bitidx == 8) begin
                last_byte = cap;
                byte_cnt = byte_cnt + 1;
                if (first) begin
                    rd_dir = cap[0];
                end else if (rd_dir) begin
                    rd_ptr = rd_ptr + 1;
                    last_mack = ack_line;
                    if (ack_line) rd_dir = 1'b0;
                end
                first = 1'b0;
                bitidx = 0;
            end else begin
                bitidx = bitidx + 1;
            end
            if (bitidx == 8) slv_pull = (first || !rd_dir) && slv_ack_en;
            else slv_pull = rd_dir && !first && !rd_q[rd_ptr % 4][7 - bitidx];
        end
        scl_p = scl_w;
        sda_p = sda_w;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_pend(input string tag);
        logic [7:0] v;
        logic seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            rd(A_CTL, v);
            if (v[4]) begin seen = 1'b1; break; end
        end
        chk(tag, 32'(seen), 32'd1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        logic seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, v);
            if (!v[5]) begin seen = 1'b1; break; end
        end
        chk(tag, 32'(seen), 32'd1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTL, v);  chk("R1 ctl", 32'(v), 0);
        rd(A_STAT, v); chk("R1 stat", 32'(v), 0);
        rd(A_OWN, v);  chk("R1 own", 32'(v), 0);
        rd(A_DATA, v); chk("R1 data", 32'(v), 0);
        rd(A_LINE, v); chk("R1 line", 32'(v), 0);
        chk("R1 lines", {30'd0, scl_oe, sda_oe}, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(A_CTL, 8'hA3); rd(A_CTL, v); chk("R2 ctl readback", 32'(v), 32'hA3);
        wr(A_CTL, 8'hB0); rd(A_CTL, v); chk("R6 write 1 to pending", 32'(v), 32'hA0);
        wr(A_OWN, 8'h5D); rd(A_OWN, v); chk("R2 own readback", 32'(v), 32'h5D);
        wr(A_LINE, 8'h96); rd(A_LINE, v); chk("R2 line readback", 32'(v), 32'h96);
        wr(A_NONE, 8'hFF); rd(A_NONE, v); chk("R2 unmapped", 32'(v), 0);
    endtask

    task automatic t_enable_off();
        logic [7:0] v;
        int s0 = start_cnt;
        wr(A_DATA, 8'hA4);
        wr(A_STAT, 8'hE0);
        repeat (200) @(negedge clk);
        rd(A_STAT, v); chk("R5 no busy without enable", 32'(v[5]), 0);
        wr(A_STAT, 8'h70);
        repeat (200) @(negedge clk);
        rd(A_STAT, v); chk("R5 no busy in slave mode", 32'(v[5]), 0);
        chk("R5 no start", 32'(start_cnt - s0), 0);
        chk("R5 scl untouched", 32'(scl_oe), 0);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        int s0, p0, b0;
        s0 = start_cnt; p0 = stop_cnt;
        slv_ack_en = 1'b1;
        wr(A_DATA, 8'hA4);
        wr(A_STAT, 8'hF0);
        rd(A_STAT, v); chk("R4 busy after start", 32'(v[5]), 1);
        wait_pend("R6 pending after address");
        chk("R4 start seen", 32'(start_cnt - s0), 1);
        chk("R4 address byte", 32'(last_byte), 32'hA4);
        chk("R3 scl period 16", 32'(rise_t[1] - rise_t[0]), 16);
        chk("R11 irq with enable", 32'(irq), 1);
        rd(A_STAT, v); chk("R7 address acked", 32'(v[0]), 0);
        b0 = byte_cnt;
        repeat (200) @(negedge clk);
        chk("R6 no activity while paused", 32'(byte_cnt - b0), 0);
        chk("R6 scl held low", 32'(scl_oe), 1);
        wr(A_DATA, 8'h3C); wr(A_CTL, 8'hA0);
        wait_pend("R6 pending after data");
        chk("R7 data byte", 32'(last_byte), 32'h3C);
        slv_ack_en = 1'b0;
        wr(A_DATA, 8'h81); wr(A_CTL, 8'hA0);
        wait_pend("R6 pending after nacked byte");
        chk("R7 data byte 2", 32'(last_byte), 32'h81);
        rd(A_STAT, v); chk("R7 nack stored", 32'(v[0]), 1);
        slv_ack_en = 1'b1;
        // repeated start in receive direction
        rd_q[0] = 8'h5A; rd_q[1] = 8'hC3; rd_ptr = 0;
        wr(A_DATA, 8'hA5); wr(A_STAT, 8'hB0); wr(A_CTL, 8'hA0);
        wait_pend("R10 pending after restart address");
        chk("R10 second start", 32'(start_cnt - s0), 2);
        chk("R10 no stop between", 32'(stop_cnt - p0), 0);
        chk("R10 read address", 32'(last_byte), 32'hA5);
        wr(A_CTL, 8'hA0);
        wait_pend("R8 pending after rx 1");
        rd(A_DATA, v); chk("R8 rx byte 1", 32'(v), 32'h5A);
        chk("R8 master ack low", 32'(last_mack), 0);
        wr(A_CTL, 8'h20);
        wait_pend("R8 pending after rx 2");
        rd(A_DATA, v); chk("R8 rx byte 2", 32'(v), 32'hC3);
        chk("R8 master nack", 32'(last_mack), 1);
        wr(A_STAT, 8'h90); wr(A_CTL, 8'hA0);
        wait_idle("R9 busy clears");
        chk("R9 stop seen", 32'(stop_cnt - p0), 1);
        chk("R9 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk("R11 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_slow_noirq();
        logic [7:0] v;
        wr(A_CTL, 8'hC0);
        wr(A_DATA, 8'hA4); wr(A_STAT, 8'hF0);
        wait_pend("R11 pending readable");
        chk("R11 irq masked", 32'(irq), 0);
        chk("R3 scl period 512", 32'(rise_t[1] - rise_t[0]), 512);
        wr(A_STAT, 8'hD0); wr(A_CTL, 8'hC0);
        wait_idle("R9 idle after slow stop");
        rd(A_STAT, v); chk("R9 busy low", 32'(v[5]), 0);
    endtask

    task automatic t_div();
        wr(A_CTL, 8'hA2);
        wr(A_DATA, 8'h6E); wr(A_STAT, 8'hF0);
        wait_pend("R3 pending div 2");
        chk("R3 scl period 48", 32'(rise_t[1] - rise_t[0]), 48);
        chk("R4 address div 2", 32'(last_byte), 32'h6E);
        wr(A_STAT, 8'hD0); wr(A_CTL, 8'hA2);
        wait_idle("R9 idle after div stop");
        wr(A_CTL, 8'hA0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_enable_off();
        t_write_read();
        t_slow_noirq();
        t_div();
        chk("R12 sda moved only with scl low", 32'(viol_cnt), 0);
        summary();
        $finish;
    end

endmodule